// File: doc/BRIEF.md
# Three-Pin Bidirectional I/O Port

This block is a 3-pin general-purpose I/O port that sits on a small synchronous register bus. Each pin has one bit in each of three registers: an output data latch, a direction register, and an analog-select register. The latch bit goes straight to the pin's output value. The pin's output-enable is the inverse of its direction bit, so a direction bit of 1 makes the pin an input and a 0 makes it drive the latch value.

Software can read back the pin levels and the latch separately. A read of the pin address returns the pin inputs after a two-flop synchronizer, with every analog-selected pin forced to 0. A read of the latch address returns the stored output value, so a read-modify-write done through the latch works on what was written, not on what the pins show. Writing either the pin address or the latch address loads the latch.

The analog-select register does not gate the driver. The direction bit still controls the output-enable, and keeping an analog pin set as an input is left to software. Out of reset, every pin is an analog input with its driver off and a latch of zero.

Top module: `gpio3_port`

## Requirements
- R1: While reset is held and right after it, the latch reads 0, the direction register reads 3'b111, the analog-select register reads 3'b111, pin_out is 0 and pin_oe is 0.
- R2: For each pin i, pin_oe[i] is the inverse of direction bit i, and a write to address 2 takes effect on pin_oe in the cycle after the write edge.
- R3: A write with bus_we high to address 0 (pin) or address 1 (latch) stores bus_wdata[2:0] in the latch, and pin_out shows it after the write edge.
- R4: A read of address 1 returns the latch contents in bits [2:0], independent of the pin levels.
- R5: A read of address 0 returns the synchronized pin levels in bits [2:0], with each pin whose analog-select bit is 1 reading as 0.
- R6: While a pin is selected as analog, its output-enable still follows its direction bit.
- R7: A pin-level change is visible in an address-0 read after exactly two rising clock edges.
- R8: Reads of address 2 (direction) and address 3 (analog select) return those registers in bits [2:0], and bits [7:3] of every read are 0.
- R9: With bus_we low, no register changes, whatever bus_addr and bus_wdata hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write enable for the register bus |
| bus_addr | input | 2 | Register select: 0 pin, 1 latch, 2 direction, 3 analog select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on bus_addr |
| pin_in | input | 3 | Pin levels, asynchronous |
| pin_out | output | 3 | Output value for each pin |
| pin_oe | output | 3 | Output driver enable for each pin |

## Verification
Random writes to all four addresses are mixed with random pin levels, and reads of every address after each step. Pin levels are chosen to differ from the latch, so a latch read that returned pin levels shows up as an error, and the reverse does too. Random analog-select masks against random pin levels separate correct masking from a mask with the wrong polarity or a missing mask. Writes with bus_we low carry random data, so a write gated on the wrong signal is caught. A directed step on the pins checks the two-cycle synchronizer latency.

// File: rtl/gpio3_pkg.sv
`timescale 1ns/1ps
package gpio3_pkg;
  localparam int unsigned BUS_AW = 2;

  typedef enum logic [BUS_AW-1:0] {
    SEL_PIN = 2'd0,
    SEL_LAT = 2'd1,
    SEL_DIR = 2'd2,
    SEL_ANA = 2'd3
  } reg_sel_e;

  // Both the pin address and the latch address load the output latch.
  function automatic logic loads_latch(input logic [BUS_AW-1:0] a);
    return (a == SEL_PIN) || (a == SEL_LAT);
  endfunction

  function automatic logic loads_dir(input logic [BUS_AW-1:0] a);
    return a == SEL_DIR;
  endfunction

  function automatic logic loads_ana(input logic [BUS_AW-1:0] a);
    return a == SEL_ANA;
  endfunction
endpackage

// File: rtl/gpio3_sync.sv
`timescale 1ns/1ps
module gpio3_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio3_regs.sv
`timescale 1ns/1ps
module gpio3_regs
  import gpio3_pkg::*;
#(
  parameter int unsigned PIN_W  = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BUS_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [PIN_W-1:0]  lat_q,
  output logic [PIN_W-1:0]  dir_q,
  output logic [PIN_W-1:0]  ana_q,
  output logic              lat_wr,
  output logic              dir_wr,
  output logic              ana_wr
);
  logic [PIN_W-1:0] wfield;

  assign wfield = wdata[PIN_W-1:0];
  assign lat_wr = we && loads_latch(addr);
  assign dir_wr = we && loads_dir(addr);
  assign ana_wr = we && loads_ana(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
      ana_q <= '1;
    end else begin
      if (lat_wr) lat_q <= wfield;
      if (dir_wr) dir_q <= wfield;
      if (ana_wr) ana_q <= wfield;
    end
  end
endmodule

// File: rtl/gpio3_rdmux.sv
`timescale 1ns/1ps
module gpio3_rdmux
  import gpio3_pkg::*;
#(
  parameter int unsigned PIN_W  = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic [BUS_AW-1:0] addr,
  input  logic [PIN_W-1:0]  pin_sync,
  input  logic [PIN_W-1:0]  lat_q,
  input  logic [PIN_W-1:0]  dir_q,
  input  logic [PIN_W-1:0]  ana_q,
  output logic [DATA_W-1:0] rdata
);
  logic [PIN_W-1:0] field;

  always_comb begin
    unique case (reg_sel_e'(addr))
      SEL_PIN: field = pin_sync & ~ana_q;
      SEL_LAT: field = lat_q;
      SEL_DIR: field = dir_q;
      SEL_ANA: field = ana_q;
      default: field = '0;
    endcase
    rdata              = '0;
    rdata[PIN_W-1:0]   = field;
  end
endmodule

// File: rtl/gpio3_port.sv
`timescale 1ns/1ps
module gpio3_port
  import gpio3_pkg::*;
#(
  parameter int unsigned PIN_W       = 3,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe
);
  logic [PIN_W-1:0] lat_q;
  logic [PIN_W-1:0] dir_q;
  logic [PIN_W-1:0] ana_q;
  logic [PIN_W-1:0] pin_sync;
  logic             lat_wr;
  logic             dir_wr;
  logic             ana_wr;

  gpio3_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  gpio3_regs #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .lat_q(lat_q), .dir_q(dir_q), .ana_q(ana_q),
    .lat_wr(lat_wr), .dir_wr(dir_wr), .ana_wr(ana_wr)
  );

  gpio3_rdmux #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_rdmux (
    .addr(bus_addr), .pin_sync(pin_sync), .lat_q(lat_q),
    .dir_q(dir_q), .ana_q(ana_q), .rdata(bus_rdata)
  );

  // Analog select never gates the driver: direction alone decides.
  assign pin_out = lat_q;
  assign pin_oe  = ~dir_q;
endmodule

// File: rtl/gpio3_port_chk.sv
`timescale 1ns/1ps
module gpio3_port_chk #(
  parameter int unsigned PIN_W  = 3,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [PIN_W-1:0]  pin_in,
  input logic [PIN_W-1:0]  pin_out,
  input logic [PIN_W-1:0]  pin_oe,
  input logic [PIN_W-1:0]  ana_q,
  input logic [PIN_W-1:0]  sync_q,
  input logic              lat_wr
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (pin_out == '0 && pin_oe == '0 && ana_q == '1));

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd2) |=> pin_oe == ~$past(bus_wdata[PIN_W-1:0]));

  p_latch_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lat_wr |=> pin_out == $past(bus_wdata[PIN_W-1:0]));

  p_latch_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 2'd1 |-> bus_rdata[PIN_W-1:0] == pin_out);

  p_analog_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 2'd0 |-> (bus_rdata[PIN_W-1:0] & ana_q) == '0);

  p_sync_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    age == 2'd2 |-> sync_q == $past(pin_in, 2));

  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:PIN_W] == '0);

  p_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(pin_out) && $stable(pin_oe) && $stable(ana_q)));
endmodule

bind gpio3_port gpio3_port_chk #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
  .pin_out(pin_out), .pin_oe(pin_oe), .ana_q(ana_q), .sync_q(pin_sync),
  .lat_wr(lat_wr)
);

// File: tb/gpio3_port_bench.sv
`timescale 1ns/1ps
module gpio3_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [2:0] pin_in = 3'd0;
  logic [2:0] pin_out;
  logic [2:0] pin_oe;

  int unsigned vectors = 0;
  int unsigned fails = 0;
  bit          done = 1'b0;

  logic [2:0] m_lat, m_dir, m_ana, m_pin;

  always #2 clk = ~clk;

  gpio3_port u_gpio3_port (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [7:0] want_read(input logic [1:0] a);
    case (a)
      2'd0:    return {5'b0, m_pin & ~m_ana};
      2'd1:    return {5'b0, m_lat};
      2'd2:    return {5'b0, m_dir};
      default: return {5'b0, m_ana};
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0;
    case (a)
      2'd0, 2'd1: m_lat = d[2:0];
      2'd2:       m_dir = d[2:0];
      default:    m_ana = d[2:0];
    endcase
  endtask

  task automatic read_check(input logic [1:0] a, input string req);
    bus_addr = a;
    #1;
    check(req, bus_rdata, want_read(a));
  endtask

  task automatic drive_check(input string req);
    check({req, " pin_out"}, {5'b0, pin_out}, {5'b0, m_lat});
    check({req, " pin_oe"}, {5'b0, pin_oe}, {5'b0, ~m_dir});
  endtask

  task automatic set_pins(input logic [2:0] p);
    pin_in = p;
    tick();
    tick();
    m_pin = p;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4417));
    m_lat = 3'b000; m_dir = 3'b111; m_ana = 3'b111; m_pin = 3'b000;
    pin_in = 3'b101;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    drive_check("R1 in reset");
    rst_n = 1'b1;
    tick();
    m_pin = 3'b101;
    tick();
    // R1: register contents after reset; R5: analog pins read as zero
    read_check(2'd1, "R1 latch");
    read_check(2'd2, "R1 dir");
    read_check(2'd3, "R1 ana");
    read_check(2'd0, "R5 all analog");
    drive_check("R1 after reset");

    // R6: analog pin still drives when direction says output
    write_reg(2'd1, 8'hFA);
    write_reg(2'd2, 8'h00);
    drive_check("R6 analog output");
    read_check(2'd0, "R5 analog masked");

    // R7: two-edge latency of the synchronizer
    write_reg(2'd3, 8'h00);
    set_pins(3'b101);
    read_check(2'd0, "R7 settled");
    pin_in = 3'b010;
    tick();
    bus_addr = 2'd0; #1;
    check("R7 one edge", bus_rdata, 8'h05);
    tick();
    bus_addr = 2'd0; #1;
    check("R7 two edges", bus_rdata, 8'h02);
    m_pin = 3'b010;

    // R4: latch read differs from pin levels
    write_reg(2'd0, 8'h05);
    read_check(2'd1, "R4 latch via pin addr");
    read_check(2'd0, "R5 pins not latch");

    for (int i = 0; i < 400; i++) begin
      int unsigned op = $urandom_range(0, 3);
      if (op == 0) begin
        write_reg(2'($urandom_range(0, 3)), 8'($urandom));
        drive_check("R3 R2 random write");
      end else if (op == 1) begin
        bus_we = 1'b0; bus_addr = 2'($urandom_range(0, 3)); bus_wdata = 8'($urandom);
        tick();
        // R9: nothing changes without write enable
        read_check(2'd1, "R9 latch");
        read_check(2'd2, "R9 dir");
        read_check(2'd3, "R9 ana");
      end else if (op == 2) begin
        set_pins(3'($urandom));
        read_check(2'd0, "R5 random pins");
      end else begin
        for (int a = 0; a < 4; a++) read_check(2'(a), "R8 readback");
        drive_check("R2 drive");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule